// File: doc/BRIEF.md
# Block Sequence Number Framer with Scheduled Trigger

This block lays block framing over a continuous sample stream. Once started, it counts clock cycles (one sample per cycle) into blocks of a fixed length. It marks the first and last sample of each block and gives every block a 64-bit sequence number. That number starts from a value set through registers and advances by one per block. A sync marker accompanies the start of every block whose distance from the start block is a whole multiple of a programmable group size.

The source can start at once or on the next rising edge of a once-per-second timing pulse. Stopping only takes effect at a block boundary, so no partial block is ever produced. A scheduling port lets software sample the running sequence number without tearing. Software can also program a 64-bit target. When the running number reaches that target, the block emits a one-cycle hit pulse on the first sample of that block. Downstream logic, such as a waveform source, uses the hit pulse to start on an exact block.

Top module: `bsn_framer`

## Requirements
- R1: After reset, `blk_sop`, `blk_eop`, `blk_sync` and `bsn_hit` are low, and `blk_bsn` and `cfg_rdata` are zero.
- R2: A write to register 0 with bit 0 = 1 and bit 1 = 0 while stopped starts the source at once. `blk_sop` is high in the cycle after the write, and `blk_bsn` then equals {register 3, register 2}.
- R3: While running, `blk_sop` marks sample 0 and `blk_eop` marks sample BLK_LEN-1 of each block. Blocks follow back to back with no gap.
- R4: `blk_sync` is high only together with `blk_sop`, on blocks whose index since start is a multiple of register 1. The value in register 1 is latched at start, and a value of 0 behaves as 1.
- R5: `blk_bsn` is constant within a block and increases by exactly one from each block to the next, carrying across bit 32.
- R6: A write to register 0 with bits [1:0] = 3 arms the source without starting it. The source starts on the first rising edge of `pps_in` seen after that. `blk_sop` is high in the cycle after `pps_in` is first sampled high.
- R7: `bsn_hit` is a one-cycle pulse coinciding with `blk_sop` of the block whose sequence number equals the committed target. A target two or more blocks beyond the current number always fires, and a hit may coincide with `blk_sync`.
- R8: A write to register 4 only stages the low 32 target bits. The target becomes {written value, staged low word} and active only when register 5 is written.
- R9: A committed target that lies behind the running sequence number never produces a hit.
- R10: A write to register 0 with bit 0 = 0 stops a running source after the `blk_eop` of the current block. Written while armed for the timing pulse, it cancels the arming.
- R11: Reads return data one cycle after `cfg_rd`. Reading register 4 returns the running number's low word and captures its high word, and reading register 5 returns that captured high word. Registers 0 to 3 read back their stored values, and registers 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Once-per-second timing pulse |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after `cfg_rd` |
| blk_sop | output | 1 | First sample of a block |
| blk_eop | output | 1 | Last sample of a block |
| blk_sync | output | 1 | Sync marker on a group's first block |
| blk_bsn | output | 64 | Sequence number of the current block |
| bsn_hit | output | 1 | Scheduled-target pulse |

## Verification
Two functions can fall in the same cycle: the scheduled hit and the sync marker, since both are qualified by the block start. The bench picks a target at least two blocks ahead whose offset from the start value is a multiple of the group size. It then counts the cycles in which both pulses are high together, and expects exactly one. A behavioural model compares every output on every clock, so any misalignment between the two pulses, or a lost marker, shows up in that same cycle.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } src_state_e;

  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SEQ_W     = 2 * WORD_W;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_GROUP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_INIT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_INIT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_SCH_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SCH_HI  = 3'd5;
endpackage

// File: rtl/bsn_cfg_regs.sv
module bsn_cfg_regs
  import bsn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic [SEQ_W-1:0]      live_seq,
  output logic [WORD_W-1:0]     cfg_rdata,
  output logic                  ctrl_wr,
  output logic                  ctrl_en,
  output logic                  ctrl_at_pps,
  output logic [WORD_W-1:0]     group_len,
  output logic [SEQ_W-1:0]      init_seq,
  output logic                  tgt_commit,
  output logic [SEQ_W-1:0]      tgt_value
);
  logic [WORD_W-1:0] ctrl_q, ctrl_n;
  logic [WORD_W-1:0] grp_q, grp_n;
  logic [WORD_W-1:0] ilo_q, ilo_n;
  logic [WORD_W-1:0] ihi_q, ihi_n;
  logic [WORD_W-1:0] stage_q, stage_n;
  logic [WORD_W-1:0] shadow_q, shadow_n;
  logic [WORD_W-1:0] rdata_q, rdata_n;
  logic              wr_en, rd_en;

  assign wr_en = cfg_wr;
  assign rd_en = cfg_rd;

  always_comb begin
    ctrl_n   = ctrl_q;
    grp_n    = grp_q;
    ilo_n    = ilo_q;
    ihi_n    = ihi_q;
    stage_n  = stage_q;
    shadow_n = shadow_q;
    rdata_n  = rdata_q;
    if (wr_en) begin
      unique case (cfg_addr)
        A_CTRL:    ctrl_n  = cfg_wdata;
        A_GROUP:   grp_n   = cfg_wdata;
        A_INIT_LO: ilo_n   = cfg_wdata;
        A_INIT_HI: ihi_n   = cfg_wdata;
        A_SCH_LO:  stage_n = cfg_wdata;
        default:   ;
      endcase
    end
    if (rd_en) begin
      unique case (cfg_addr)
        A_CTRL:    rdata_n = ctrl_q;
        A_GROUP:   rdata_n = grp_q;
        A_INIT_LO: rdata_n = ilo_q;
        A_INIT_HI: rdata_n = ihi_q;
        A_SCH_LO: begin
          rdata_n  = live_seq[WORD_W-1:0];
          shadow_n = live_seq[SEQ_W-1:WORD_W];
        end
        A_SCH_HI:  rdata_n = shadow_q;
        default:   rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      grp_q    <= '0;
      ilo_q    <= '0;
      ihi_q    <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en) begin
        ctrl_q  <= ctrl_n;
        grp_q   <= grp_n;
        ilo_q   <= ilo_n;
        ihi_q   <= ihi_n;
        stage_q <= stage_n;
      end
      if (rd_en) begin
        shadow_q <= shadow_n;
        rdata_q  <= rdata_n;
      end
    end
  end

  assign cfg_rdata   = rdata_q;
  assign ctrl_wr     = cfg_wr && (cfg_addr == A_CTRL);
  assign ctrl_en     = cfg_wdata[0];
  assign ctrl_at_pps = cfg_wdata[1];
  assign group_len   = grp_q;
  assign init_seq    = {ihi_q, ilo_q};
  assign tgt_commit  = cfg_wr && (cfg_addr == A_SCH_HI);
  assign tgt_value   = {cfg_wdata, stage_q};
endmodule

// File: rtl/bsn_frame_core.sv
module bsn_frame_core
  import bsn_pkg::*;
#(
  parameter int unsigned BLK_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_en,
  input  logic              ctrl_at_pps,
  input  logic              pps_edge,
  input  logic [SEQ_W-1:0]  init_seq,
  input  logic [WORD_W-1:0] group_len,
  output logic              sop,
  output logic              eop,
  output logic              sync,
  output logic [SEQ_W-1:0]  seq,
  output logic              active
);
  localparam int unsigned CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_LEN - 1);

  src_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] blk_q, blk_n;
  logic [WORD_W-1:0] grp_q, grp_n;
  logic [SEQ_W-1:0]  seq_q, seq_n;
  logic              stop_q, stop_n;
  logic              stop_eff, go, running;

  assign running = (state_q == ST_RUN);
  assign sop     = running && (cnt_q == '0);
  assign eop     = running && (cnt_q == LAST);
  assign sync    = sop && (blk_q == '0);
  assign seq     = seq_q;
  assign active  = running;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    blk_n    = blk_q;
    grp_n    = grp_q;
    seq_n    = seq_q;
    stop_n   = stop_q;
    stop_eff = stop_q;
    go       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ctrl_wr && ctrl_en) begin
          if (ctrl_at_pps) state_n = ST_WAIT;
          else             go      = 1'b1;
        end
      end
      ST_WAIT: begin
        if (ctrl_wr && !ctrl_en) state_n = ST_IDLE;
        else if (pps_edge)       go      = 1'b1;
      end
      ST_RUN: begin
        stop_eff = ctrl_wr ? !ctrl_en : stop_q;
        stop_n   = stop_eff;
        if (eop) begin
          cnt_n = '0;
          seq_n = seq_q + 1'b1;
          blk_n = (blk_q == grp_q - 1'b1) ? '0 : blk_q + 1'b1;
          if (stop_eff) begin
            state_n = ST_IDLE;
            stop_n  = 1'b0;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (go) begin
      state_n = ST_RUN;
      cnt_n   = '0;
      blk_n   = '0;
      seq_n   = init_seq;
      grp_n   = (group_len == '0) ? WORD_W'(1) : group_len;
      stop_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
      grp_q   <= '0;
      seq_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      stop_q  <= stop_n;
      if (running || go) begin
        cnt_q <= cnt_n;
        blk_q <= blk_n;
        seq_q <= seq_n;
      end
      if (go) grp_q <= grp_n;
    end
  end
endmodule

// File: rtl/bsn_trigger.sv
module bsn_trigger
  import bsn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic [SEQ_W-1:0] seq,
  input  logic             tgt_commit,
  input  logic [SEQ_W-1:0] tgt_value,
  output logic             hit
);
  logic [SEQ_W-1:0] tgt_q;
  logic             armed_q, armed_n;

  assign hit = sop && armed_q && (seq == tgt_q);

  always_comb begin
    armed_n = armed_q;
    if (tgt_commit) armed_n = 1'b1;
    else if (hit)   armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_n;
      if (tgt_commit) tgt_q <= tgt_value;
    end
  end
endmodule

// File: rtl/bsn_framer.sv
module bsn_framer
  import bsn_pkg::*;
#(
  parameter int unsigned BLK_LEN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps_in,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        blk_sop,
  output logic        blk_eop,
  output logic        blk_sync,
  output logic [63:0] blk_bsn,
  output logic        bsn_hit
);
  logic              rs1_q, rst_sn;
  logic              pps_q, pps_edge;
  logic              ctrl_wr, ctrl_en, ctrl_at_pps;
  logic [WORD_W-1:0] group_len;
  logic [SEQ_W-1:0]  init_seq, tgt_value;
  logic              tgt_commit;
  logic              run_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_sn <= rs1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pps_q <= 1'b0;
    else         pps_q <= pps_in;
  end
  assign pps_edge = pps_in && !pps_q;

  bsn_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .live_seq   (blk_bsn),
    .cfg_rdata  (cfg_rdata),
    .ctrl_wr    (ctrl_wr),
    .ctrl_en    (ctrl_en),
    .ctrl_at_pps(ctrl_at_pps),
    .group_len  (group_len),
    .init_seq   (init_seq),
    .tgt_commit (tgt_commit),
    .tgt_value  (tgt_value)
  );

  bsn_frame_core #(.BLK_LEN(BLK_LEN)) u_core (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ctrl_wr    (ctrl_wr),
    .ctrl_en    (ctrl_en),
    .ctrl_at_pps(ctrl_at_pps),
    .pps_edge   (pps_edge),
    .init_seq   (init_seq),
    .group_len  (group_len),
    .sop        (blk_sop),
    .eop        (blk_eop),
    .sync       (blk_sync),
    .seq        (blk_bsn),
    .active     (run_w)
  );

  bsn_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_sn),
    .sop       (blk_sop),
    .seq       (blk_bsn),
    .tgt_commit(tgt_commit),
    .tgt_value (tgt_value),
    .hit       (bsn_hit)
  );
endmodule

// File: rtl/bsn_framer_chk.sv
module bsn_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        sop,
  input logic        eop,
  input logic        sync,
  input logic        hit,
  input logic [63:0] bsn
);
  assert_sync_on_sop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> sop);

  assert_hit_on_sop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> sop);

  assert_hit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop) ##1 active |-> sop);

  assert_bsn_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eop ##1 (active && sop) |-> bsn == $past(bsn) + 64'd1);

  assert_bsn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sop) |-> $stable(bsn));
endmodule

bind bsn_framer bsn_framer_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sn),
  .active(run_w),
  .sop   (blk_sop),
  .eop   (blk_eop),
  .sync  (blk_sync),
  .hit   (bsn_hit),
  .bsn   (blk_bsn)
);

// File: tb/sim_bsn_framer.sv
`timescale 1ns/1ps
module sim_bsn_framer;
  localparam int L = 8;

  logic        clk;
  logic        rst_n;
  logic        pps_in;
  logic        cfg_wr, cfg_rd;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        blk_sop, blk_eop, blk_sync, bsn_hit;
  logic [63:0] blk_bsn;

  bsn_framer #(.BLK_LEN(L)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .blk_sop(blk_sop), .blk_eop(blk_eop), .blk_sync(blk_sync),
    .blk_bsn(blk_bsn), .bsn_hit(bsn_hit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int              m_rcnt;
  int              m_state;   // 0 stopped, 1 waiting for pps, 2 running
  int              m_cnt, m_blk, m_grp;
  bit              m_stop, m_pps, m_armed;
  longint unsigned m_bsn, m_tgt;
  int unsigned     m_ctrl, m_grp_reg, m_ilo, m_ihi, m_stage, m_shadow, m_rdata;

  function automatic bit e_sop();  return m_state == 2 && m_cnt == 0;     endfunction
  function automatic bit e_eop();  return m_state == 2 && m_cnt == L - 1; endfunction
  function automatic bit e_sync(); return e_sop() && m_blk == 0;          endfunction
  function automatic bit e_hit();  return e_sop() && m_armed && m_bsn == m_tgt; endfunction

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_blk = 0; m_grp = 0; m_stop = 0; m_pps = 0;
    m_armed = 0; m_bsn = 0; m_tgt = 0; m_ctrl = 0; m_grp_reg = 0; m_ilo = 0;
    m_ihi = 0; m_stage = 0; m_shadow = 0; m_rdata = 0;
  endtask

  task automatic model_step();
    bit sop, eop, hit, edge_seen, go, stop_now;
    longint unsigned init;
    sop = e_sop(); eop = e_eop(); hit = e_hit();
    edge_seen = pps_in && !m_pps;
    m_pps = pps_in;
    init = {m_ihi, m_ilo};
    if (cfg_rd) begin
      case (cfg_addr)
        3'd0: m_rdata = m_ctrl;
        3'd1: m_rdata = m_grp_reg;
        3'd2: m_rdata = m_ilo;
        3'd3: m_rdata = m_ihi;
        3'd4: begin m_rdata = m_bsn[31:0]; m_shadow = m_bsn[63:32]; end
        3'd5: m_rdata = m_shadow;
        default: m_rdata = 0;
      endcase
    end
    if (cfg_wr && cfg_addr == 3'd5) begin
      m_tgt = {cfg_wdata, m_stage}; m_armed = 1;
    end else if (hit) m_armed = 0;
    go = 0;
    if (m_state == 0) begin
      if (cfg_wr && cfg_addr == 0 && cfg_wdata[0]) begin
        if (cfg_wdata[1]) m_state = 1; else go = 1;
      end
    end else if (m_state == 1) begin
      if (cfg_wr && cfg_addr == 0 && !cfg_wdata[0]) m_state = 0;
      else if (edge_seen) go = 1;
    end else begin
      if (cfg_wr && cfg_addr == 0) m_stop = !cfg_wdata[0];
      stop_now = m_stop;
      if (eop) begin
        m_cnt = 0; m_bsn = m_bsn + 1;
        m_blk = (m_blk + 1) % m_grp;
        if (stop_now) begin m_state = 0; m_stop = 0; end
      end else m_cnt++;
    end
    if (go) begin
      m_state = 2; m_cnt = 0; m_blk = 0; m_bsn = init; m_stop = 0;
      m_grp = (m_grp_reg == 0) ? 1 : int'(m_grp_reg);
    end
    if (cfg_wr) begin
      case (cfg_addr)
        3'd0: m_ctrl = cfg_wdata;
        3'd1: m_grp_reg = cfg_wdata;
        3'd2: m_ilo = cfg_wdata;
        3'd3: m_ihi = cfg_wdata;
        3'd4: m_stage = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_rcnt = 0; model_reset(); end
    else if (m_rcnt < 2) begin m_rcnt++; model_reset(); end
    else model_step();
  end

  // ---------------- per-cycle comparison and event counters ----------------
  bit cmp_on = 0;
  int n_sop, n_sync, n_hit, n_both;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(blk_sop == e_sop(),   "R3 sop",  blk_sop,  e_sop());
      chk(blk_eop == e_eop(),   "R3 eop",  blk_eop,  e_eop());
      chk(blk_sync == e_sync(), "R4 sync", blk_sync, e_sync());
      chk(blk_bsn == m_bsn,     "R5 bsn",  blk_bsn,  m_bsn);
      chk(bsn_hit == e_hit(),   "R7 hit",  bsn_hit,  e_hit());
      chk(cfg_rdata == m_rdata, "R11 rdata", cfg_rdata, m_rdata);
    end
    if (blk_sop) n_sop++;
    if (blk_sync) n_sync++;
    if (bsn_hit) n_hit++;
    if (bsn_hit && blk_sync) n_both++;
  end

  task automatic clr_counts();
    n_sop = 0; n_sync = 0; n_hit = 0; n_both = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  task automatic rd_bsn(output longint unsigned v);
    logic [31:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    v = {hi, lo};
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog for all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    longint unsigned cur, t, init;
    logic [31:0] d;
    rst_n = 0; pps_in = 0; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_wdata = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    cmp_on = 1;
    // R1 reset state
    chk(!blk_sop && !blk_eop && !blk_sync && !bsn_hit, "R1 strobes", {blk_sop, blk_eop, blk_sync, bsn_hit}, 0);
    chk(blk_bsn == 0 && cfg_rdata == 0, "R1 bsn/rdata", blk_bsn, 0);

    // R2 immediate start from an initial value close to the 32-bit carry
    init = 64'h1_FFFF_FFFE;
    wr(3'd1, 32'd4);
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'd1);
    wr(3'd0, 32'd1);
    chk(blk_sop == 1, "R2 first sop", blk_sop, 1);
    chk(blk_bsn == init, "R2 start bsn", blk_bsn, init);
    clr_counts();
    idle(8 * L - 1);
    chk(n_sop == 8, "R3 blocks back to back", n_sop, 8);
    chk(n_sync == 2, "R4 sync every 4 blocks", n_sync, 2);

    // R11 register read-back and tear-free live number
    rd(3'd1, d);
    chk(d == 4, "R11 group readback", d, 4);
    rd_bsn(cur);
    chk(cur >= init + 8 && cur <= init + 9, "R11 live bsn range", cur, init + 8);
    chk(cur > 64'h1_FFFF_FFFF, "R5 carry across bit 32", cur, 64'h2_0000_0000);

    // R8 staged low word alone does not arm
    rd_bsn(cur);
    wr(3'd4, 32'(cur + 2));
    clr_counts();
    idle(5 * L);
    chk(n_hit == 0, "R8 no hit before commit", n_hit, 0);
    // R9 committing now puts the target in the past
    wr(3'd5, 32'((cur + 2) >> 32));
    clr_counts();
    idle(6 * L);
    chk(n_hit == 0, "R9 past target silent", n_hit, 0);

    // R7 target ahead, aligned to a sync block: hit and sync together
    rd_bsn(cur);
    t = cur + 2;
    while (((t - init) % 4) != 0) t++;
    clr_counts();
    wr(3'd4, t[31:0]);
    wr(3'd5, t[63:32]);
    idle(int'(t - cur + 2) * L);
    chk(n_hit == 1, "R7 single hit", n_hit, 1);
    chk(n_both == 1, "R7 hit with sync", n_both, 1);

    // R10 stop at the block boundary
    idle(3);
    wr(3'd0, 32'd0);
    idle(L);
    clr_counts();
    idle(3 * L);
    chk(n_sop == 0 && blk_eop == 0, "R10 stopped", n_sop, 0);

    // R6 start on timing pulse
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd3);
    clr_counts();
    idle(3 * L);
    chk(n_sop == 0, "R6 waits for pps", n_sop, 0);
    pps_in = 1;
    @(negedge clk);
    chk(blk_sop == 1 && blk_bsn == 100, "R6 sop after pps", blk_bsn, 100);
    idle(4);
    pps_in = 0;
    idle(2 * L);
    wr(3'd0, 32'd0);
    idle(2 * L);

    // R10 cancel while waiting for pps
    wr(3'd0, 32'd3);
    idle(5);
    wr(3'd0, 32'd0);
    pps_in = 1;
    clr_counts();
    idle(3 * L);
    pps_in = 0;
    chk(n_sop == 0, "R10 cancel armed start", n_sop, 0);

    // R4 group length zero acts as one
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    clr_counts();
    idle(4 * L);
    chk(n_sync == n_sop && n_sop >= 4, "R4 zero group", n_sync, n_sop);
    rd(3'd0, d);
    chk(d == 1, "R11 ctrl readback", d, 1);
    rd(3'd6, d);
    chk(d == 0, "R11 unused reads zero", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule